// File: doc/BRIEF.md
# Static Prefix Code Builder

This block turns a set of symbol weights into a static minimum-redundancy prefix code. Software or a neighbouring block writes one weight per symbol through a load port, then pulses `start`. The block treats each nonzero weight as a leaf, keeps merging the two lightest live nodes into one node carrying their summed weight, and counts for every symbol how many merges its subtree has taken part in. That count is the symbol's code length.

Once the tree is complete, code words are given out canonically from the lengths alone. The result therefore does not depend on which child of a merge would have received a 0 or a 1. While the block works, `busy` is high and the readout port returns zeros. When it finishes, `done` rises and stays high until the next accepted start. Any symbol's length and code word can then be read combinationally by index.

Top module: `huff_builder`

## Requirements
- R1: After reset `busy` and `done` are low, and every symbol reads back with length 0 and code 0.
- R2: A symbol whose weight is zero is kept out of the tree and reads back with length 0 and code 0. If every weight is zero, every symbol reads 0/0.
- R3: With weights (index 0..5) 29, 5, 7, 12, 4, 8, the lengths are 1, 4, 3, 3, 4, 3.
- R4: The lengths equal those of the following process. Live nodes start as the nonzero symbols, each in its own slot. Each step picks the lightest live node, with ties going to the lower slot, and then the lightest of the others, with the same tie rule. It adds the second into the first slot, retires the second slot, and adds one to the length of every symbol under either node. This repeats until one node remains.
- R5: Codes are canonical. Levels are visited from 1 upward with a running base that starts at 0. At each level, the symbols of that length in ascending index order take base, base+1, and so on. The base then becomes (base + count at that level) shifted left by one. A code word sits in the low `len` bits of `rd_code`, MSB first.
- R6: When exactly one weight is nonzero, that symbol gets length 1 and code 0.
- R7: `done` stays high until a start pulse is accepted. The cycle after the pulse, `done` is low and `busy` is high. A start pulse while busy is ignored.
- R8: While `busy` is high, `rd_len` and `rd_code` are zero.
- R9: Weight loads presented while busy are ignored. The stored weights keep their values for the next run.
- R10: With two or more nonzero weights, the code lengths fill the code space exactly: the sum of 2^(5-len) over nonzero symbols is 32.
- R11: A run stays busy for at most N + N - 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Write `load_wt` into the weight of `load_sym` (idle only) |
| load_sym | input | 3 | Symbol index for the load |
| load_wt | input | 8 | Weight value |
| start | input | 1 | Single-cycle pulse that begins a build |
| rd_sym | input | 3 | Symbol index to read out |
| busy | output | 1 | Build in progress |
| done | output | 1 | Build complete; held until the next start |
| rd_len | output | 3 | Code length of `rd_sym` |
| rd_code | output | 5 | Code word of `rd_sym`, right-aligned |

## Verification
The bench targets tie handling by sweeping hundreds of weight sets. Many of these are drawn from a tiny range, so equal weights are common. A design that broke ties the other way, or kept the merged node in the wrong slot, would report lengths that differ from the model's. Zero weights, a single live symbol and an all-zero set are driven on purpose. Mishandling these shows up as a zero-weight symbol with a nonzero length, a lone symbol left at length 0, or a build that never ends. Loads and starts issued mid-build check that the stored weights and the running build are left untouched. Hold checks on `done` catch a flag that drops on its own.

// File: rtl/huff_builder.sv
module huff_builder #(
  parameter int N  = 6,
  parameter int WW = 8,
  localparam int SYMW = $clog2(N),
  localparam int LW   = $clog2(N),
  localparam int CW   = N - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SYMW-1:0] load_sym,
  input  logic [WW-1:0]   load_wt,
  input  logic            start,
  input  logic [SYMW-1:0] rd_sym,
  output logic            busy,
  output logic            done,
  output logic [LW-1:0]   rd_len,
  output logic [CW-1:0]   rd_code
);
  localparam int SW   = WW + SYMW;
  localparam int CNTW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_MERGE, S_CANON} st_t;
  st_t state;

  logic [WW-1:0]   freq [N];
  logic [SW-1:0]   wt   [N];
  logic [N-1:0]    grp  [N];
  logic [N-1:0]    act;
  logic [LW-1:0]   len  [N];
  logic [CW-1:0]   code [N];
  logic [LW-1:0]   lvl;
  logic [CW:0]     base;

  logic [SYMW-1:0] ia, ib;
  logic            fa, fb;
  logic [N-1:0]    ugrp;
  logic [CNTW-1:0] rank [N];
  logic [CNTW-1:0] cnt;

  always_comb begin
    ia = '0; ib = '0; fa = 1'b0; fb = 1'b0;
    for (int i = 0; i < N; i++)
      if (act[i] && (!fa || wt[i] < wt[ia])) begin
        ia = SYMW'(i); fa = 1'b1;
      end
    for (int i = 0; i < N; i++)
      if (act[i] && SYMW'(i) != ia && (!fb || wt[i] < wt[ib])) begin
        ib = SYMW'(i); fb = 1'b1;
      end
  end

  assign ugrp = grp[ia] | grp[ib];

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = cnt;
      if (len[i] == lvl) cnt = cnt + CNTW'(1);
    end
  end

  assign busy    = (state != S_IDLE);
  assign rd_len  = (busy || rd_sym >= SYMW'(N)) ? '0 : len[rd_sym];
  assign rd_code = (busy || rd_sym >= SYMW'(N)) ? '0 : code[rd_sym];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      act   <= '0;
      lvl   <= '0;
      base  <= '0;
      for (int i = 0; i < N; i++) begin
        freq[i] <= '0;
        wt[i]   <= '0;
        grp[i]  <= '0;
        len[i]  <= '0;
        code[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (load && load_sym < SYMW'(N)) freq[load_sym] <= load_wt;
          if (start) begin
            done  <= 1'b0;
            state <= S_MERGE;
            for (int i = 0; i < N; i++) begin
              wt[i]   <= SW'(freq[i]);
              act[i]  <= (freq[i] != '0);
              grp[i]  <= N'(1) << i;
              len[i]  <= '0;
              code[i] <= '0;
            end
          end
        end
        S_MERGE: begin
          if (fb) begin
            wt[ia]  <= wt[ia] + wt[ib];
            grp[ia] <= ugrp;
            act[ib] <= 1'b0;
            for (int i = 0; i < N; i++)
              if (ugrp[i]) len[i] <= len[i] + LW'(1);
          end else begin
            if (fa)
              for (int i = 0; i < N; i++)
                if (grp[ia][i] && len[i] == '0) len[i] <= LW'(1);
            lvl   <= LW'(1);
            base  <= '0;
            state <= S_CANON;
          end
        end
        S_CANON: begin
          for (int i = 0; i < N; i++)
            if (len[i] == lvl) code[i] <= base[CW-1:0] + CW'(rank[i]);
          base <= (base + (CW+1)'(cnt)) << 1;
          lvl  <= lvl + LW'(1);
          if (lvl == LW'(CW)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module huff_builder_chk #(
  parameter int N  = 6,
  parameter int WW = 8,
  localparam int SYMW = $clog2(N),
  localparam int LW   = $clog2(N),
  localparam int CW   = N - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [LW-1:0]   rd_len,
  input logic [CW-1:0]   rd_code
);
  localparam int LIMIT = N + CW;
  logic [$clog2(LIMIT+2)-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;

  p_busy_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= LIMIT);
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_start_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));
  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  p_quiet_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_len == '0 && rd_code == '0));
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_len <= LW'(CW));
  p_code_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len != '0) |-> ((rd_code >> rd_len) == '0));
endmodule

bind huff_builder huff_builder_chk #(.N(N), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_len(rd_len), .rd_code(rd_code)
);

// File: tb/tb_huff_builder.sv
module tb_huff_builder;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int WW = 8;
  localparam int CW = N - 1;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, start = 1'b0;
  logic [2:0] load_sym = '0, rd_sym = '0;
  logic [WW-1:0] load_wt = '0;
  logic busy, done;
  logic [2:0] rd_len;
  logic [CW-1:0] rd_code;

  int n_chk = 0, n_fail = 0;
  int el [N];
  int ec [N];
  int w  [N];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  huff_builder #(.N(N), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_sym(load_sym), .load_wt(load_wt),
    .start(start), .rd_sym(rd_sym), .busy(busy), .done(done),
    .rd_len(rd_len), .rd_code(rd_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic model();
    int mw [N]; int mg [N]; bit ma [N]; int live, base, c;
    live = 0;
    for (int i = 0; i < N; i++) begin
      mw[i] = w[i]; mg[i] = 1 << i; ma[i] = (w[i] != 0); el[i] = 0; ec[i] = 0;
      if (ma[i]) live++;
    end
    while (live > 1) begin
      int a = -1, b = -1;
      for (int i = 0; i < N; i++) if (ma[i] && (a < 0 || mw[i] < mw[a])) a = i;
      for (int i = 0; i < N; i++) if (ma[i] && i != a && (b < 0 || mw[i] < mw[b])) b = i;
      mw[a] += mw[b]; mg[a] |= mg[b]; ma[b] = 0; live--;
      for (int i = 0; i < N; i++) if ((mg[a] >> i) & 1) el[i]++;
    end
    if (live == 1) for (int i = 0; i < N; i++) if (ma[i] && el[i] == 0) el[i] = 1;
    base = 0;
    for (int l = 1; l <= CW; l++) begin
      c = 0;
      for (int i = 0; i < N; i++) if (el[i] == l) begin ec[i] = base + c; c++; end
      base = (base + c) << 1;
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); load = 1'b1; load_sym = 3'(i); load_wt = WW'(w[i]);
    end
    @(negedge clk); load = 1'b0;
  endtask

  task automatic run();
    int t = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk(done, "R11 build finishes", t, 0);
  endtask

  task automatic compare(input string req);
    int kraft = 0, nz = 0;
    for (int i = 0; i < N; i++) begin
      rd_sym = 3'(i); #1;
      chk(int'(rd_len) == el[i], {req, " len"}, int'(rd_len), el[i]);
      chk(int'(rd_code) == ec[i], {req, " R5 code"}, int'(rd_code), ec[i]);
      if (w[i] != 0) begin nz++; kraft += 1 << (CW - int'(rd_len)); end
      else chk(rd_len == 0 && rd_code == 0, "R2 zero weight excluded", int'(rd_len), 0);
    end
    if (nz >= 2) chk(kraft == (1 << CW), "R10 code space full", kraft, 1 << CW);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    for (int i = 0; i < N; i++) begin
      rd_sym = 3'(i); #1;
      chk(rd_len == 0 && rd_code == 0, "R1 reset readout", int'(rd_len), 0);
    end
    rst_n = 1'b1;

    // R3 worked case
    w = '{29, 5, 7, 12, 4, 8};
    load_all(); run(); model();
    begin
      int exl [N] = '{1, 4, 3, 3, 4, 3};
      int exc [N] = '{0, 14, 4, 5, 15, 6};
      for (int i = 0; i < N; i++) begin
        rd_sym = 3'(i); #1;
        chk(int'(rd_len) == exl[i], "R3 length", int'(rd_len), exl[i]);
        chk(int'(rd_code) == exc[i], "R5 code", int'(rd_code), exc[i]);
      end
    end

    // R7 done holds, R8 quiet while busy, R9 load ignored
    repeat (5) @(negedge clk);
    chk(done, "R7 done holds", done, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy && !done, "R7 start clears done", {busy, done}, 2);
    rd_sym = 3'd0; #1;
    chk(rd_len == 0 && rd_code == 0, "R8 readout zero when busy", int'(rd_len), 0);
    load = 1'b1; load_sym = 3'd0; load_wt = 8'd1;
    start = 1'b1;
    @(negedge clk); load = 1'b0; start = 1'b0;
    chk(busy, "R7 start while busy ignored", busy, 1);
    while (!done) @(negedge clk);
    compare("R9 load during build");
    run(); compare("R9 stored weight kept");

    // R6 single live symbol
    for (int s = 0; s < N; s++) begin
      for (int i = 0; i < N; i++) w[i] = (i == s) ? 3 + s : 0;
      load_all(); run(); model();
      rd_sym = 3'(s); #1;
      chk(rd_len == 1 && rd_code == 0, "R6 single symbol", int'(rd_len), 1);
      compare("R6 others");
    end

    // R2 all zero
    w = '{0, 0, 0, 0, 0, 0};
    load_all(); run(); model(); compare("R2 all zero");

    // R4 all tied
    w = '{10, 10, 10, 10, 10, 10};
    load_all(); run(); model(); compare("R4 all tied");

    // R4 sweep
    for (int k = 0; k < 500; k++) begin
      for (int i = 0; i < N; i++) begin
        seed = nxt(seed);
        if (seed[11:9] == 3'd0) w[i] = 0;
        else if (k[0]) w[i] = int'(seed[2:0]);
        else w[i] = int'(seed[7:0]);
      end
      load_all(); run(); model(); compare("R4 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule